// File: doc/BRIEF.md
# Serial 0-1-1 Pattern Detector with Toggle-Register State

This block watches a one-bit serial stream, taking one bit on each rising clock edge, and flags every place where the three most recent bits read 0, then 1, then 1. The flag is combinational from the present input and the stored state, so it is high during the same cycle in which the closing 1 is presented. Once a match is reported the machine returns to its idle condition.

The state lives in two toggle-type storage bits. Each bit flips on a clock edge when its toggle enable is 1 and holds when the enable is 0. The enables come from minimized excitation equations rather than a direct next-state assignment. The fourth, unused state code is not simply left unhandled: the same equations steer it back into a legal state within one cycle. The two-bit state is brought out for observation.

Reset is asynchronous and active-low. Its release is re-timed to the clock inside the block, so the state bits start updating on the third rising edge after `rst_ni` goes high. A parameter selects the code that reset loads. Its default is the idle code. Any other value exists only so that recovery from an illegal code can be exercised through reset.

Top module: `pat011_det`

## Requirements
- R1: While the internal reset is active, state_o shows the reset code (parameter RST_STATE, default 2'b00 = idle) and hit_o is 0 for any din_i. Asserting rst_ni low clears the state at once, without waiting for a clock edge. Release of rst_ni takes effect through a two-stage synchronizer, so the first state update happens on the third rising edge after release.
- R2: An input of 0 moves the state to 2'b01 (seen "0") on the next edge, whatever the present state.
- R3: From idle (2'b00), an input of 1 keeps the state at 2'b00 and leaves hit_o at 0.
- R4: From seen "0" (2'b01), an input of 1 moves the state to 2'b10 (seen "01").
- R5: From seen "01" (2'b10), an input of 1 raises hit_o in that cycle and returns the state to 2'b00 on the edge.
- R6: hit_o is high only when din_i is 1 and state_o is 2'b10. It never stays high for two cycles in a row.
- R7: Bit 1 of the state toggles when (Q1 OR (X AND Q0)) is 1. Bit 0 toggles when ((NOT X AND NOT Q0) OR (X AND Q0)) is 1. Each bit holds its value otherwise.
- R8: From the unused code 2'b11, an input of 0 leads to 2'b01 and an input of 1 leads to 2'b00. hit_o stays 0 in both cases.
- R9: After reset, hit_o equals the test "the last three bits, oldest first, are 0,1,1", with the bits before reset treated as 1s. The stream 0,1,1,0,1,1 therefore gives pulses on its third and sixth bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous active-low reset, release re-timed inside |
| din_i | input | 1 | Serial data bit, taken on each rising edge |
| hit_o | output | 1 | High in the cycle that completes a 0,1,1 pattern |
| state_o | output | 2 | Present state code: 00 idle, 01 seen "0", 10 seen "01", 11 unused |

## Verification
A wrong toggle enable appears on state_o on the very next rising edge, because each transition moves at least one bit to a code that can be predicted. A corrupted state reaches hit_o only when the machine should be in 2'b10 with a 1 arriving, or wrongly sits there, so a fault can stay hidden on the flag for several bits. For that reason state_o is compared every cycle against a model of the last three bits, alongside the flag. Recovery from 2'b11 is observed at the ports within one edge, by loading that code through reset.

// File: rtl/pat011_pkg.sv
package pat011_pkg;
  localparam int STATE_W = 2;

  typedef logic [STATE_W-1:0] code_t;

  localparam code_t ST_IDLE  = 2'b00;
  localparam code_t ST_ZERO  = 2'b01;
  localparam code_t ST_ZO    = 2'b10;
  localparam code_t ST_SPARE = 2'b11;
endpackage

// File: rtl/pat011_rstsync.sv
module pat011_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[TOP-1:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[TOP];
endmodule

// File: rtl/pat011_excite.sv
module pat011_excite
  import pat011_pkg::*;
(
  input  logic  din_i,
  input  code_t q_i,
  output code_t tgl_o,
  output logic  hit_o
);
  logic q1, q0;

  assign q1 = q_i[1];
  assign q0 = q_i[0];

  // Minimized toggle enables; code 11 resolves to 01 (din=0) or 00 (din=1).
  always_comb begin
    tgl_o[1] = q1 | (din_i & q0);
    tgl_o[0] = (~din_i & ~q0) | (din_i & q0);
  end

  // Mealy flag: closing 1 while in seen-"01".
  always_comb begin
    hit_o = din_i & q1 & ~q0;
  end
endmodule

// File: rtl/pat011_tbit.sv
module pat011_tbit #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tgl_i,
  output logic q_o
);
  logic q_r;
  logic q_nxt;

  always_comb begin
    if (tgl_i) begin
      q_nxt = ~q_r;
    end else begin
      q_nxt = q_r;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_r <= RST_VAL;
    end else begin
      q_r <= q_nxt;
    end
  end

  assign q_o = q_r;
endmodule

// File: rtl/pat011_det.sv
module pat011_det #(
  parameter logic [pat011_pkg::STATE_W-1:0] RST_STATE = pat011_pkg::ST_IDLE,
  parameter int SYNC_STAGES = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           din_i,
  output logic                           hit_o,
  output logic [pat011_pkg::STATE_W-1:0] state_o
);
  import pat011_pkg::*;

  logic  rst_n_q;
  code_t state_q;
  code_t tgl;

  pat011_rstsync #(
    .STAGES(SYNC_STAGES)
  ) u_rstsync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n_q)
  );

  pat011_excite u_excite (
    .din_i(din_i),
    .q_i  (state_q),
    .tgl_o(tgl),
    .hit_o(hit_o)
  );

  for (genvar b = 0; b < STATE_W; b++) begin : g_bit
    pat011_tbit #(
      .RST_VAL(RST_STATE[b])
    ) u_bit (
      .clk_i (clk_i),
      .rst_ni(rst_n_q),
      .tgl_i (tgl[b]),
      .q_o   (state_q[b])
    );
  end

  assign state_o = state_q;
endmodule

// File: rtl/pat011_det_chk.sv
module pat011_det_chk (
  input logic       clk_i,
  input logic       rst_n,
  input logic       din_i,
  input logic       hit_o,
  input logic [1:0] state_o
);
  // R2
  p_zero_to_seen0_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    rst_n && !din_i |=> state_o == 2'b01);

  // R3
  p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    rst_n && din_i && state_o == 2'b00 |=> state_o == 2'b00);

  // R4
  p_seen0_adv_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    rst_n && din_i && state_o == 2'b01 |=> state_o == 2'b10);

  // R5
  p_hit_return_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    rst_n && hit_o |=> state_o == 2'b00);

  // R6
  p_hit_single_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    rst_n && hit_o |=> !hit_o);

  // R8
  p_spare_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    rst_n && state_o == 2'b11 |-> !hit_o);

  // R8
  p_spare_exit_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    rst_n && din_i && state_o == 2'b11 |=> state_o == 2'b00);
endmodule

bind pat011_det pat011_det_chk u_chk (
  .clk_i  (clk_i),
  .rst_n  (rst_n_q),
  .din_i  (din_i),
  .hit_o  (hit_o),
  .state_o(state_o)
);

// File: tb/pat011_det_tb_top.sv
module pat011_det_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int QTR = CLK_PERIOD / 4;
  localparam int N_VEC = 16;
  localparam int N_RAND = 3000;

  // Each entry: {din, expected hit, expected state after the edge}
  localparam logic [3:0] VEC [N_VEC] = '{
    4'b0_0_01, 4'b1_0_10, 4'b1_1_00, 4'b0_0_01,
    4'b1_0_10, 4'b1_1_00, 4'b1_0_00, 4'b0_0_01,
    4'b0_0_01, 4'b1_0_10, 4'b0_0_01, 4'b1_0_10,
    4'b1_1_00, 4'b1_0_00, 4'b0_0_01, 4'b1_0_10
  };

  logic       clk;
  logic       rst_ni;
  logic       din;
  logic       din_sp;
  logic       hit;
  logic       hit_sp;
  logic [1:0] st;
  logic [1:0] st_sp;

  int n_chk;
  int n_bad;
  bit done;

  pat011_det dut_i (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .din_i  (din),
    .hit_o  (hit),
    .state_o(st)
  );

  pat011_det #(
    .RST_STATE(2'b11)
  ) dut_sp_i (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .din_i  (din_sp),
    .hit_o  (hit_sp),
    .state_o(st_sp)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [2:0]  hist;
    logic [15:0] lfsr;
    logic [1:0]  exp_st;
    logic        exp_hit;
    n_chk = 0;
    n_bad = 0;
    done = 1'b0;
    din = 1'b1;
    din_sp = 1'b1;
    rst_ni = 1'b0;

    // R1: reset state
    do_reset();
    #QTR;
    check(st == 2'b00, "R1 reset state", st, 0);
    check(hit == 1'b0, "R1 reset flag", hit, 0);
    @(negedge clk);
    check(st == 2'b00, "R3 idle holds on 1", st, 0);

    // Vector table: R2 R3 R4 R5 R6 R7 R9
    for (int i = 0; i < N_VEC; i++) begin
      din = VEC[i][3];
      #QTR;
      check(hit == VEC[i][2], "R5/R6/R9 flag vector", hit, VEC[i][2]);
      @(negedge clk);
      check(st == VEC[i][1:0], "R2/R3/R4/R7 state vector", st, VEC[i][1:0]);
    end

    // R1: asynchronous clear from seen-"01"
    check(st == 2'b10, "R1 precondition", st, 2);
    rst_ni = 1'b0;
    #1;
    check(st == 2'b00, "R1 async clear", st, 0);
    din = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    din = 1'b0;
    @(negedge clk);
    check(st == 2'b00, "R1 sync release, edge 1", st, 0);
    @(negedge clk);
    check(st == 2'b00, "R1 sync release, edge 2", st, 0);
    @(negedge clk);
    check(st == 2'b01, "R1 first live edge", st, 1);

    // R9 R7: random stream against a last-three-bits model
    din = 1'b1;
    do_reset();
    hist = 3'b111;
    lfsr = 16'hACE1;
    for (int i = 0; i < N_RAND; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      din = lfsr[0] & (lfsr[5] | lfsr[9]) ^ lfsr[3];
      exp_hit = ({hist[1:0], din} == 3'b011);
      #QTR;
      check(hit == exp_hit, "R9 random flag", hit, exp_hit);
      @(negedge clk);
      hist = {hist[1:0], din};
      if (hist[1:0] == 2'b01) exp_st = 2'b10;
      else if (!hist[0]) exp_st = 2'b01;
      else exp_st = 2'b00;
      check(st == exp_st, "R7 random state", st, exp_st);
    end

    // R8: recovery from the unused code, input 0
    din = 1'b1;
    din_sp = 1'b0;
    do_reset();
    check(st_sp == 2'b11, "R8 spare loaded", st_sp, 3);
    #QTR;
    check(hit_sp == 1'b0, "R8 no flag on 0", hit_sp, 0);
    @(negedge clk);
    check(st_sp == 2'b01, "R8 spare exits to 01", st_sp, 1);

    // R8: recovery from the unused code, input 1
    din_sp = 1'b1;
    do_reset();
    check(st_sp == 2'b11, "R8 spare loaded again", st_sp, 3);
    #QTR;
    check(hit_sp == 1'b0, "R8 no flag on 1", hit_sp, 0);
    @(negedge clk);
    check(st_sp == 2'b00, "R8 spare exits to 00", st_sp, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule